// File: doc/BRIEF.md
# Single-Cycle Accumulator Control Sequencer

This block is the control heart of a small accumulator machine with separate instruction and data memories. Each clock cycle it takes one 40-bit instruction word (an 8-bit opcode above a 32-bit operand), decodes the low six opcode bits, and produces the control fields for an external accumulator ALU, an eight-entry register file and a data memory. It also owns the program counter and the stack pointer.

The next program counter comes from one of five sources: the incremented PC, the operand as an absolute target, the PC plus the operand, the accumulator value, or the unchanged PC when the machine halts. All control outputs are registered. They describe the instruction that was on `instr_i` during the previous cycle, and the PC register advances on that same edge. The instruction memory reads `pc_o` and returns the next word. Flags come from the ALU and are sampled together with the branch instruction that tests them.

Top module: `accum_sequencer`

## Requirements
- R1: While `rst` is high, and on the first clock edge with `rst` high, `pc_o`, the stack pointer and every output become 0, except `alu_cmd_o`, which becomes the pass code 0010.
- R2: Only opcode bits 5..0 (`instr_i[37:32]`) select the instruction, and bits 7..6 are ignored. Codes 100110 through 111011 behave as NOP.
- R3: ALU command and source, written as opcode:cmd/src. Source codes are 00 memory, 01 immediate, 10 register, 11 constant one. The table: 000000:0000/10, 000001:0000/00, 000010:0000/01, 000011:0001/10, 000100:0001/00, 000101:0001/01, 000110:0000/11, 000111:0001/11, 001000:0111, 001001:1000, 001010:1010, 001011:1011, 001100:1110, 001101:1111, 001110:0100/10, 001111:0101/10, 010000:0110/10, 010001:1100, 010010:1001, 011100:1101, 011110:0011/01, 011111:0011, 100011:0011/10, 100101:0011, 111101:0011. Entries with no source listed use source 00. Every other opcode gives 0010/00.
- R4: Opcode 010011 loads the low 16 operand bits into the PC. Opcodes 010100, 010101, 010110 and 011000 do the same when Z, OV, C or EQ (respectively) is 1, and otherwise increment the PC.
- R5: Opcode 010111 sets PC to PC plus the operand, modulo 2^16. Opcode 011101 sets PC to the accumulator.
- R6: `imm_o` carries the operand for every opcode except 011110, which carries the PC of that instruction, zero-extended.
- R7: Opcode 111111 leaves the PC unchanged. NOP 111110, and every opcode not covered by R4 or R5, increments the PC by 1.
- R8: `rf_rd_sel_o` is operand bits 2..0. With opcode 100001, `rf_we_o` = 00000001 and `rf_in_sel_o` = 01. With opcode 100010, `rf_we_o` = 00000001 and `rf_in_sel_o` = 11. With opcode 100100, `rf_we_o` = operand bits 7..0 and `rf_in_sel_o` = 10. For all other opcodes both fields are 0.
- R9: `flag_clr_o` bit 0 (Z) is set by opcode 011001, bit 1 (OV) by 011010 and bit 2 (C) by 011011. It is 0 otherwise.
- R10: For opcodes 000001, 000100, 011111, 100000 and 100010, `dm_addr_o` is operand bits 7..0. For 100101 it is accumulator bits 7..0. Opcode 100000 asserts `dm_we_o`. `dm_wdata_o` always carries the accumulator. When no address source applies, `dm_addr_o` is 0.
- R11: PUSH 111100 writes at address SP (`dm_we_o` = 1) and then SP becomes SP+1. POP 111101 reads at address SP−1 and then SP becomes SP−1. SP is 8 bits and wraps.
- R12: Every control output changes on the edge that ends the cycle in which its instruction was presented, and `pc_o` changes on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_i | input | 40 | Opcode in bits 39..32, operand in bits 31..0 |
| acc_i | input | 16 | Current accumulator value |
| flag_z_i | input | 1 | Zero flag |
| flag_ov_i | input | 1 | Overflow flag |
| flag_c_i | input | 1 | Carry flag |
| flag_eq_i | input | 1 | Equal flag |
| pc_o | output | 16 | Program counter (instruction memory address) |
| alu_cmd_o | output | 4 | ALU command |
| alu_src_o | output | 2 | ALU second-operand source |
| imm_o | output | 32 | Immediate value to the ALU |
| rf_rd_sel_o | output | 3 | Register read select |
| rf_we_o | output | 8 | One-hot register write enables |
| rf_in_sel_o | output | 2 | Register input mux select |
| flag_clr_o | output | 3 | Flag clear mask {C, OV, Z} |
| dm_addr_o | output | 8 | Data memory address |
| dm_we_o | output | 1 | Data memory write enable |
| dm_wdata_o | output | 16 | Data memory write data |

## Verification
Every result of an instruction is due exactly one clock edge after that instruction and its flags and accumulator are applied. This covers the control fields, the memory address, the write enable and the new `pc_o`. The SP change caused by a PUSH or POP shows up one instruction later, in the address of the next stack access. The bench applies each vector at a falling edge and advances its behavioural model of PC and SP at the same moment. It then compares every output at the next falling edge, so each comparison falls after exactly one rising edge. Stack wrap is checked by a POP at SP 0 whose address must read 255.

// File: rtl/seq_pkg.sv
package seq_pkg;

  localparam logic [5:0] OPC_ADD_R   = 6'b000000;
  localparam logic [5:0] OPC_ADD_M   = 6'b000001;
  localparam logic [5:0] OPC_ADD_I   = 6'b000010;
  localparam logic [5:0] OPC_SUB_R   = 6'b000011;
  localparam logic [5:0] OPC_SUB_M   = 6'b000100;
  localparam logic [5:0] OPC_SUB_I   = 6'b000101;
  localparam logic [5:0] OPC_INC     = 6'b000110;
  localparam logic [5:0] OPC_DEC     = 6'b000111;
  localparam logic [5:0] OPC_SAR     = 6'b001000;
  localparam logic [5:0] OPC_SAL     = 6'b001001;
  localparam logic [5:0] OPC_SHU     = 6'b001010;
  localparam logic [5:0] OPC_SHD     = 6'b001011;
  localparam logic [5:0] OPC_RRC     = 6'b001100;
  localparam logic [5:0] OPC_RLC     = 6'b001101;
  localparam logic [5:0] OPC_AND_R   = 6'b001110;
  localparam logic [5:0] OPC_OR_R    = 6'b001111;
  localparam logic [5:0] OPC_XOR_R   = 6'b010000;
  localparam logic [5:0] OPC_NOT     = 6'b010001;
  localparam logic [5:0] OPC_NEG     = 6'b010010;
  localparam logic [5:0] OPC_JMP     = 6'b010011;
  localparam logic [5:0] OPC_JZ      = 6'b010100;
  localparam logic [5:0] OPC_JOV     = 6'b010101;
  localparam logic [5:0] OPC_JC      = 6'b010110;
  localparam logic [5:0] OPC_JREL    = 6'b010111;
  localparam logic [5:0] OPC_JEQ     = 6'b011000;
  localparam logic [5:0] OPC_CLR_Z   = 6'b011001;
  localparam logic [5:0] OPC_CLR_OV  = 6'b011010;
  localparam logic [5:0] OPC_CLR_C   = 6'b011011;
  localparam logic [5:0] OPC_CLR_ACC = 6'b011100;
  localparam logic [5:0] OPC_ACC2PC  = 6'b011101;
  localparam logic [5:0] OPC_PC2ACC  = 6'b011110;
  localparam logic [5:0] OPC_LD_M    = 6'b011111;
  localparam logic [5:0] OPC_STORE   = 6'b100000;
  localparam logic [5:0] OPC_R0_I    = 6'b100001;
  localparam logic [5:0] OPC_R0_M    = 6'b100010;
  localparam logic [5:0] OPC_LD_R    = 6'b100011;
  localparam logic [5:0] OPC_ACC2R   = 6'b100100;
  localparam logic [5:0] OPC_LD_IND  = 6'b100101;
  localparam logic [5:0] OPC_PUSH    = 6'b111100;
  localparam logic [5:0] OPC_POP     = 6'b111101;
  localparam logic [5:0] OPC_NOP     = 6'b111110;
  localparam logic [5:0] OPC_HALT    = 6'b111111;

  localparam logic [3:0] CMD_ADD  = 4'h0;
  localparam logic [3:0] CMD_SUB  = 4'h1;
  localparam logic [3:0] CMD_PASS = 4'h2;
  localparam logic [3:0] CMD_LOAD = 4'h3;
  localparam logic [3:0] CMD_AND  = 4'h4;
  localparam logic [3:0] CMD_OR   = 4'h5;
  localparam logic [3:0] CMD_XOR  = 4'h6;
  localparam logic [3:0] CMD_SAR  = 4'h7;
  localparam logic [3:0] CMD_SAL  = 4'h8;
  localparam logic [3:0] CMD_NEG  = 4'h9;
  localparam logic [3:0] CMD_SHU  = 4'hA;
  localparam logic [3:0] CMD_SHD  = 4'hB;
  localparam logic [3:0] CMD_NOT  = 4'hC;
  localparam logic [3:0] CMD_CLR  = 4'hD;
  localparam logic [3:0] CMD_RRC  = 4'hE;
  localparam logic [3:0] CMD_RLC  = 4'hF;

  localparam logic [1:0] SRC_MEM = 2'b00;
  localparam logic [1:0] SRC_IMM = 2'b01;
  localparam logic [1:0] SRC_REG = 2'b10;
  localparam logic [1:0] SRC_ONE = 2'b11;

  localparam logic [1:0] RIN_NONE = 2'b00;
  localparam logic [1:0] RIN_IMM  = 2'b01;
  localparam logic [1:0] RIN_ACC  = 2'b10;
  localparam logic [1:0] RIN_MEM  = 2'b11;

  typedef enum logic [2:0] {
    NPC_INC, NPC_TGT, NPC_REL, NPC_ACC, NPC_HOLD
  } npc_sel_e;

  typedef enum logic [1:0] {
    SP_KEEP, SP_PUSH, SP_POP
  } sp_op_e;

  typedef enum logic [2:0] {
    DA_NONE, DA_OPND, DA_ACC, DA_SP, DA_SPM1
  } da_sel_e;

  typedef struct packed {
    logic [3:0] alu_cmd;
    logic [1:0] alu_src;
    logic [1:0] rf_in_sel;
    logic       we_r0;
    logic       we_opnd;
    logic [2:0] flag_clr;
    logic       imm_pc;
    logic       dm_we;
    da_sel_e    da_sel;
    npc_sel_e   npc_sel;
    sp_op_e     sp_op;
  } dec_t;

endpackage

// File: rtl/seq_decode.sv
module seq_decode
  import seq_pkg::*;
(
  input  logic [5:0] opc,
  input  logic       fz,
  input  logic       fov,
  input  logic       fc,
  input  logic       feq,
  output dec_t       dec
);

  always_comb begin
    dec          = '0;
    dec.alu_cmd  = CMD_PASS;
    dec.alu_src  = SRC_MEM;
    dec.npc_sel  = NPC_INC;
    dec.sp_op    = SP_KEEP;
    dec.da_sel   = DA_NONE;
    case (opc)
      OPC_ADD_R:   begin dec.alu_cmd = CMD_ADD; dec.alu_src = SRC_REG; end
      OPC_ADD_M:   begin dec.alu_cmd = CMD_ADD; dec.da_sel = DA_OPND; end
      OPC_ADD_I:   begin dec.alu_cmd = CMD_ADD; dec.alu_src = SRC_IMM; end
      OPC_SUB_R:   begin dec.alu_cmd = CMD_SUB; dec.alu_src = SRC_REG; end
      OPC_SUB_M:   begin dec.alu_cmd = CMD_SUB; dec.da_sel = DA_OPND; end
      OPC_SUB_I:   begin dec.alu_cmd = CMD_SUB; dec.alu_src = SRC_IMM; end
      OPC_INC:     begin dec.alu_cmd = CMD_ADD; dec.alu_src = SRC_ONE; end
      OPC_DEC:     begin dec.alu_cmd = CMD_SUB; dec.alu_src = SRC_ONE; end
      OPC_SAR:     dec.alu_cmd = CMD_SAR;
      OPC_SAL:     dec.alu_cmd = CMD_SAL;
      OPC_SHU:     dec.alu_cmd = CMD_SHU;
      OPC_SHD:     dec.alu_cmd = CMD_SHD;
      OPC_RRC:     dec.alu_cmd = CMD_RRC;
      OPC_RLC:     dec.alu_cmd = CMD_RLC;
      OPC_AND_R:   begin dec.alu_cmd = CMD_AND; dec.alu_src = SRC_REG; end
      OPC_OR_R:    begin dec.alu_cmd = CMD_OR;  dec.alu_src = SRC_REG; end
      OPC_XOR_R:   begin dec.alu_cmd = CMD_XOR; dec.alu_src = SRC_REG; end
      OPC_NOT:     dec.alu_cmd = CMD_NOT;
      OPC_NEG:     dec.alu_cmd = CMD_NEG;
      OPC_JMP:     dec.npc_sel = NPC_TGT;
      OPC_JZ:      dec.npc_sel = fz  ? NPC_TGT : NPC_INC;
      OPC_JOV:     dec.npc_sel = fov ? NPC_TGT : NPC_INC;
      OPC_JC:      dec.npc_sel = fc  ? NPC_TGT : NPC_INC;
      OPC_JEQ:     dec.npc_sel = feq ? NPC_TGT : NPC_INC;
      OPC_JREL:    dec.npc_sel = NPC_REL;
      OPC_CLR_Z:   dec.flag_clr = 3'b001;
      OPC_CLR_OV:  dec.flag_clr = 3'b010;
      OPC_CLR_C:   dec.flag_clr = 3'b100;
      OPC_CLR_ACC: dec.alu_cmd = CMD_CLR;
      OPC_ACC2PC:  dec.npc_sel = NPC_ACC;
      OPC_PC2ACC:  begin
        dec.alu_cmd = CMD_LOAD;
        dec.alu_src = SRC_IMM;
        dec.imm_pc  = 1'b1;
      end
      OPC_LD_M:    begin dec.alu_cmd = CMD_LOAD; dec.da_sel = DA_OPND; end
      OPC_STORE:   begin dec.dm_we = 1'b1; dec.da_sel = DA_OPND; end
      OPC_R0_I:    begin dec.we_r0 = 1'b1; dec.rf_in_sel = RIN_IMM; end
      OPC_R0_M:    begin
        dec.we_r0     = 1'b1;
        dec.rf_in_sel = RIN_MEM;
        dec.da_sel    = DA_OPND;
      end
      OPC_LD_R:    begin dec.alu_cmd = CMD_LOAD; dec.alu_src = SRC_REG; end
      OPC_ACC2R:   begin dec.we_opnd = 1'b1; dec.rf_in_sel = RIN_ACC; end
      OPC_LD_IND:  begin dec.alu_cmd = CMD_LOAD; dec.da_sel = DA_ACC; end
      OPC_PUSH:    begin
        dec.dm_we  = 1'b1;
        dec.da_sel = DA_SP;
        dec.sp_op  = SP_PUSH;
      end
      OPC_POP:     begin
        dec.alu_cmd = CMD_LOAD;
        dec.da_sel  = DA_SPM1;
        dec.sp_op   = SP_POP;
      end
      OPC_HALT:    dec.npc_sel = NPC_HOLD;
      default:     ;
    endcase
  end

endmodule

// File: rtl/seq_pc_unit.sv
module seq_pc_unit
  import seq_pkg::*;
#(
  parameter int PC_W   = 16,
  parameter int OPND_W = 32,
  parameter int ACC_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  npc_sel_e          npc_sel,
  input  logic [OPND_W-1:0] opnd,
  input  logic [ACC_W-1:0]  acc,
  output logic [PC_W-1:0]   pc_q
);

  localparam logic [PC_W-1:0] PC_ONE = PC_W'(1);

  logic [PC_W-1:0] pc_n;
  logic            unused_src;

  assign unused_src = ^{opnd, acc};

  always_comb begin
    case (npc_sel)
      NPC_TGT:  pc_n = PC_W'(opnd);
      NPC_REL:  pc_n = pc_q + PC_W'(opnd);
      NPC_ACC:  pc_n = PC_W'(acc);
      NPC_HOLD: pc_n = pc_q;
      default:  pc_n = pc_q + PC_ONE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) pc_q <= '0;
    else     pc_q <= pc_n;
  end

  // R7
  pc_step_chk: assert property (@(posedge clk) disable iff (rst)
    (npc_sel == NPC_INC) |=> (pc_q == $past(pc_q) + PC_ONE));

  // R5
  pc_acc_chk: assert property (@(posedge clk) disable iff (rst)
    (npc_sel == NPC_ACC) |=> (pc_q == PC_W'($past(acc))));

  // R4
  pc_tgt_chk: assert property (@(posedge clk) disable iff (rst)
    (npc_sel == NPC_TGT) |=> (pc_q == PC_W'($past(opnd))));

endmodule

// File: rtl/seq_stack.sv
module seq_stack
  import seq_pkg::*;
#(
  parameter int DM_AW  = 8,
  parameter int OPND_W = 32,
  parameter int ACC_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  sp_op_e            sp_op,
  input  da_sel_e           da_sel,
  input  logic [OPND_W-1:0] opnd,
  input  logic [ACC_W-1:0]  acc,
  output logic [DM_AW-1:0]  addr_n
);

  localparam logic [DM_AW-1:0] SP_ONE = DM_AW'(1);

  logic [DM_AW-1:0] sp_q;
  logic             unused_src;

  assign unused_src = ^{opnd, acc};

  always_comb begin
    case (da_sel)
      DA_OPND: addr_n = DM_AW'(opnd);
      DA_ACC:  addr_n = DM_AW'(acc);
      DA_SP:   addr_n = sp_q;
      DA_SPM1: addr_n = sp_q - SP_ONE;
      default: addr_n = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) sp_q <= '0;
    else begin
      case (sp_op)
        SP_PUSH: sp_q <= sp_q + SP_ONE;
        SP_POP:  sp_q <= sp_q - SP_ONE;
        default: sp_q <= sp_q;
      endcase
    end
  end

  // R11
  sp_push_chk: assert property (@(posedge clk) disable iff (rst)
    (sp_op == SP_PUSH) |=> (sp_q == $past(sp_q) + SP_ONE));

  // R11
  sp_pop_chk: assert property (@(posedge clk) disable iff (rst)
    (sp_op == SP_POP) |=> (sp_q == $past(sp_q) - SP_ONE));

  // R11
  sp_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (sp_op == SP_KEEP) |=> $stable(sp_q));

endmodule

// File: rtl/accum_sequencer.sv
module accum_sequencer
  import seq_pkg::*;
#(
  parameter  int OPND_W  = 32,
  parameter  int PC_W    = 16,
  parameter  int ACC_W   = 16,
  parameter  int DM_AW   = 8,
  parameter  int RF_N    = 8,
  localparam int INSTR_W = OPND_W + 8,
  localparam int RSEL_W  = $clog2(RF_N)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [INSTR_W-1:0] instr_i,
  input  logic [ACC_W-1:0]   acc_i,
  input  logic               flag_z_i,
  input  logic               flag_ov_i,
  input  logic               flag_c_i,
  input  logic               flag_eq_i,
  output logic [PC_W-1:0]    pc_o,
  output logic [3:0]         alu_cmd_o,
  output logic [1:0]         alu_src_o,
  output logic [OPND_W-1:0]  imm_o,
  output logic [RSEL_W-1:0]  rf_rd_sel_o,
  output logic [RF_N-1:0]    rf_we_o,
  output logic [1:0]         rf_in_sel_o,
  output logic [2:0]         flag_clr_o,
  output logic [DM_AW-1:0]   dm_addr_o,
  output logic               dm_we_o,
  output logic [ACC_W-1:0]   dm_wdata_o
);

  localparam logic [RF_N-1:0] R0_HOT = RF_N'(1);

  logic [5:0]        opc;
  logic [OPND_W-1:0] opnd;
  logic              unused_rsv;
  dec_t              dec;
  logic [DM_AW-1:0]  addr_n;

  assign opc        = instr_i[OPND_W+5:OPND_W];
  assign opnd       = instr_i[OPND_W-1:0];
  assign unused_rsv = ^instr_i[INSTR_W-1:OPND_W+6];

  seq_decode u_dec (
    .opc (opc),
    .fz  (flag_z_i),
    .fov (flag_ov_i),
    .fc  (flag_c_i),
    .feq (flag_eq_i),
    .dec (dec)
  );

  seq_pc_unit #(.PC_W(PC_W), .OPND_W(OPND_W), .ACC_W(ACC_W)) u_pc (
    .clk     (clk),
    .rst     (rst),
    .npc_sel (dec.npc_sel),
    .opnd    (opnd),
    .acc     (acc_i),
    .pc_q    (pc_o)
  );

  seq_stack #(.DM_AW(DM_AW), .OPND_W(OPND_W), .ACC_W(ACC_W)) u_stk (
    .clk    (clk),
    .rst    (rst),
    .sp_op  (dec.sp_op),
    .da_sel (dec.da_sel),
    .opnd   (opnd),
    .acc    (acc_i),
    .addr_n (addr_n)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      alu_cmd_o   <= CMD_PASS;
      alu_src_o   <= '0;
      imm_o       <= '0;
      rf_rd_sel_o <= '0;
      rf_we_o     <= '0;
      rf_in_sel_o <= '0;
      flag_clr_o  <= '0;
      dm_addr_o   <= '0;
      dm_we_o     <= 1'b0;
      dm_wdata_o  <= '0;
    end else begin
      alu_cmd_o   <= dec.alu_cmd;
      alu_src_o   <= dec.alu_src;
      imm_o       <= dec.imm_pc ? OPND_W'(pc_o) : opnd;
      rf_rd_sel_o <= opnd[RSEL_W-1:0];
      rf_we_o     <= dec.we_r0   ? R0_HOT :
                     dec.we_opnd ? opnd[RF_N-1:0] : '0;
      rf_in_sel_o <= dec.rf_in_sel;
      flag_clr_o  <= dec.flag_clr;
      dm_addr_o   <= addr_n;
      dm_we_o     <= dec.dm_we;
      dm_wdata_o  <= acc_i;
    end
  end

  // R7
  halt_pc_chk: assert property (@(posedge clk) disable iff (rst)
    (opc == OPC_HALT) |=> $stable(pc_o));

  // R11
  push_write_chk: assert property (@(posedge clk) disable iff (rst)
    (opc == OPC_PUSH) |=> (dm_we_o && (dm_wdata_o == $past(acc_i))));

  // R10
  store_addr_chk: assert property (@(posedge clk) disable iff (rst)
    (opc == OPC_STORE) |=> (dm_we_o && (dm_addr_o == DM_AW'($past(opnd)))));

  // R8
  we_excl_chk: assert property (@(posedge clk) disable iff (rst)
    dm_we_o |-> (rf_we_o == '0));

endmodule

// File: tb/accum_sequencer_test.sv
module accum_sequencer_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [39:0] instr = '0;
  logic [15:0] acc = '0;
  logic        fz = 0, fov = 0, fc = 0, feq = 0;

  logic [15:0] pc_o;
  logic [3:0]  alu_cmd_o;
  logic [1:0]  alu_src_o;
  logic [31:0] imm_o;
  logic [2:0]  rf_rd_sel_o;
  logic [7:0]  rf_we_o;
  logic [1:0]  rf_in_sel_o;
  logic [2:0]  flag_clr_o;
  logic [7:0]  dm_addr_o;
  logic        dm_we_o;
  logic [15:0] dm_wdata_o;

  int vectors = 0;
  int miscompares = 0;
  bit vec_bad;
  bit done = 0;

  logic [15:0] m_pc;
  logic [7:0]  m_sp;
  logic [15:0] e_pc;
  logic [3:0]  e_cmd;
  logic [1:0]  e_src;
  logic [31:0] e_imm;
  logic [2:0]  e_rsel;
  logic [7:0]  e_we;
  logic [1:0]  e_rin;
  logic [2:0]  e_clr;
  logic [7:0]  e_addr;
  logic        e_dwe;
  logic [15:0] e_wdata;

  always #2 clk = ~clk;

  accum_sequencer uut (
    .clk(clk), .rst(rst), .instr_i(instr), .acc_i(acc),
    .flag_z_i(fz), .flag_ov_i(fov), .flag_c_i(fc), .flag_eq_i(feq),
    .pc_o(pc_o), .alu_cmd_o(alu_cmd_o), .alu_src_o(alu_src_o),
    .imm_o(imm_o), .rf_rd_sel_o(rf_rd_sel_o), .rf_we_o(rf_we_o),
    .rf_in_sel_o(rf_in_sel_o), .flag_clr_o(flag_clr_o),
    .dm_addr_o(dm_addr_o), .dm_we_o(dm_we_o), .dm_wdata_o(dm_wdata_o)
  );

  task automatic cmp(input string req, input string fld,
                     input logic [31:0] act, input logic [31:0] exp);
    if (act !== exp) begin
      $display("FAIL %s %s actual=%h expected=%h", req, fld, act, exp);
      vec_bad = 1'b1;
    end
  endtask

  task automatic check_all(input string req);
    vec_bad = 1'b0;
    cmp(req, "pc",     32'(pc_o),        32'(e_pc));
    cmp(req, "cmd",    32'(alu_cmd_o),   32'(e_cmd));
    cmp(req, "src",    32'(alu_src_o),   32'(e_src));
    cmp(req, "imm",    imm_o,            e_imm);
    cmp(req, "rsel",   32'(rf_rd_sel_o), 32'(e_rsel));
    cmp(req, "rf_we",  32'(rf_we_o),     32'(e_we));
    cmp(req, "rin",    32'(rf_in_sel_o), 32'(e_rin));
    cmp(req, "clr",    32'(flag_clr_o),  32'(e_clr));
    cmp(req, "daddr",  32'(dm_addr_o),   32'(e_addr));
    cmp(req, "dwe",    32'(dm_we_o),     32'(e_dwe));
    cmp(req, "wdata",  32'(dm_wdata_o),  32'(e_wdata));
    vectors++;
    if (vec_bad) miscompares++;
  endtask

  // Behavioural model of one instruction, from the requirement table.
  task automatic model(input int op, input logic [31:0] opd,
                       input logic [15:0] a, input logic [3:0] fl);
    logic [15:0] npc;
    npc = m_pc + 16'd1;
    e_cmd = 4'h2; e_src = 2'd0; e_imm = opd; e_rsel = opd[2:0];
    e_we = 8'd0; e_rin = 2'd0; e_clr = 3'd0; e_addr = 8'd0;
    e_dwe = 1'b0; e_wdata = a;
    case (op)
      0:  begin e_cmd = 0; e_src = 2; end
      1:  begin e_cmd = 0; e_addr = opd[7:0]; end
      2:  begin e_cmd = 0; e_src = 1; end
      3:  begin e_cmd = 1; e_src = 2; end
      4:  begin e_cmd = 1; e_addr = opd[7:0]; end
      5:  begin e_cmd = 1; e_src = 1; end
      6:  begin e_cmd = 0; e_src = 3; end
      7:  begin e_cmd = 1; e_src = 3; end
      8:  e_cmd = 7;
      9:  e_cmd = 8;
      10: e_cmd = 10;
      11: e_cmd = 11;
      12: e_cmd = 14;
      13: e_cmd = 15;
      14: begin e_cmd = 4; e_src = 2; end
      15: begin e_cmd = 5; e_src = 2; end
      16: begin e_cmd = 6; e_src = 2; end
      17: e_cmd = 12;
      18: e_cmd = 9;
      19: npc = opd[15:0];
      20: if (fl[0]) npc = opd[15:0];
      21: if (fl[1]) npc = opd[15:0];
      22: if (fl[2]) npc = opd[15:0];
      23: npc = m_pc + opd[15:0];
      24: if (fl[3]) npc = opd[15:0];
      25: e_clr = 3'b001;
      26: e_clr = 3'b010;
      27: e_clr = 3'b100;
      28: e_cmd = 13;
      29: npc = a;
      30: begin e_cmd = 3; e_src = 1; e_imm = {16'd0, m_pc}; end
      31: begin e_cmd = 3; e_addr = opd[7:0]; end
      32: begin e_dwe = 1; e_addr = opd[7:0]; end
      33: begin e_we = 8'd1; e_rin = 1; end
      34: begin e_we = 8'd1; e_rin = 3; e_addr = opd[7:0]; end
      35: begin e_cmd = 3; e_src = 2; end
      36: begin e_we = opd[7:0]; e_rin = 2; end
      37: begin e_cmd = 3; e_addr = a[7:0]; end
      60: begin e_dwe = 1; e_addr = m_sp; m_sp = m_sp + 8'd1; end
      61: begin e_cmd = 3; e_addr = m_sp - 8'd1; m_sp = m_sp - 8'd1; end
      63: npc = m_pc;
      default: ;
    endcase
    m_pc = npc;
    e_pc = npc;
  endtask

  task automatic run(input int op, input logic [1:0] rsv,
                     input logic [31:0] opd, input logic [15:0] a,
                     input logic [3:0] fl, input string req);
    instr = {rsv, 6'(op), opd};
    acc = a;
    {feq, fc, fov, fz} = fl;
    model(op, opd, a, fl);
    @(negedge clk);
    check_all(req);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      $display("FAIL watchdog expired actual=running expected=finished");
      miscompares++;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    m_pc = 0; m_sp = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    e_pc = 0; e_cmd = 4'h2; e_src = 0; e_imm = 0; e_rsel = 0; e_we = 0;
    e_rin = 0; e_clr = 0; e_addr = 0; e_dwe = 0; e_wdata = 0;
    check_all("R1");
    rst = 1'b0;

    // R3 ALU command table
    for (int i = 0; i <= 18; i++) run(i, 2'b00, 32'h0000_00A5 + i, 16'h1234 + 16'(i), 4'h0, "R3");
    run(28, 2'b00, 32'h0, 16'h0, 4'h0, "R3");
    run(35, 2'b00, 32'h5, 16'h0, 4'h0, "R3");
    // R2 reserved bits ignored, undefined codes as NOP
    run(2, 2'b11, 32'h0000_0077, 16'h0, 4'h0, "R2");
    run(38, 2'b10, 32'hFFFF_FFFF, 16'h0, 4'h0, "R2");
    run(59, 2'b01, 32'h0000_00FF, 16'h0, 4'h0, "R2");
    // R4 jumps
    run(19, 2'b00, 32'h0001_0100, 16'h0, 4'h0, "R4");
    run(20, 2'b00, 32'h0000_0200, 16'h0, 4'h0, "R4");
    run(20, 2'b00, 32'h0000_0200, 16'h0, 4'h1, "R4");
    run(21, 2'b00, 32'h0000_0300, 16'h0, 4'hD, "R4");
    run(21, 2'b00, 32'h0000_0300, 16'h0, 4'h2, "R4");
    run(22, 2'b00, 32'h0000_0400, 16'h0, 4'hB, "R4");
    run(22, 2'b00, 32'h0000_0400, 16'h0, 4'h4, "R4");
    run(24, 2'b00, 32'h0000_0500, 16'h0, 4'h7, "R4");
    run(24, 2'b00, 32'h0000_0500, 16'h0, 4'h8, "R4");
    // R5 relative (including wrap) and accumulator target
    run(23, 2'b00, 32'h0000_0010, 16'h0, 4'h0, "R5");
    run(23, 2'b00, 32'hFFFF_FFFE, 16'h0, 4'h0, "R5");
    run(23, 2'b00, 32'h0000_FFF0, 16'h0, 4'h0, "R5");
    run(29, 2'b00, 32'h0, 16'hBEEF, 4'h0, "R5");
    // R6 PC capture
    run(30, 2'b00, 32'hDEAD_0000, 16'h0, 4'h0, "R6");
    // R7 halt and nop
    run(63, 2'b00, 32'h0, 16'h0, 4'hF, "R7");
    run(63, 2'b00, 32'h0, 16'h0, 4'h0, "R7");
    run(62, 2'b00, 32'h0, 16'h0, 4'h0, "R7");
    // R8 register file fields
    run(33, 2'b00, 32'h0000_0042, 16'h0, 4'h0, "R8");
    run(34, 2'b00, 32'h0000_0019, 16'h0, 4'h0, "R8");
    run(36, 2'b00, 32'h0000_0080, 16'h0, 4'h0, "R8");
    run(36, 2'b00, 32'h0000_0003, 16'h0, 4'h0, "R8");
    // R9 flag clears
    run(25, 2'b00, 32'h0, 16'h0, 4'h0, "R9");
    run(26, 2'b00, 32'h0, 16'h0, 4'h0, "R9");
    run(27, 2'b00, 32'h0, 16'h0, 4'h0, "R9");
    // R10 memory addressing
    run(31, 2'b00, 32'h0000_01C3, 16'h0, 4'h0, "R10");
    run(32, 2'b00, 32'h0000_0055, 16'hCAFE, 4'h0, "R10");
    run(37, 2'b00, 32'h0, 16'h12E7, 4'h0, "R10");
    // R11 stack: pop at empty wraps, then pushes and pops
    run(61, 2'b00, 32'h0, 16'h0, 4'h0, "R11");
    run(60, 2'b00, 32'h0, 16'h1111, 4'h0, "R11");
    run(60, 2'b00, 32'h0, 16'h2222, 4'h0, "R11");
    run(60, 2'b00, 32'h0, 16'h3333, 4'h0, "R11");
    run(61, 2'b00, 32'h0, 16'h0, 4'h0, "R11");
    run(61, 2'b00, 32'h0, 16'h0, 4'h0, "R11");
    // R12 mixed stream, one result per edge
    for (int k = 0; k < 400; k++) begin
      int op;
      op = int'($urandom_range(0, 63));
      run(op, 2'($urandom), $urandom, 16'($urandom), 4'($urandom), "R12");
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule